// File: doc/BRIEF.md
# Spatial Noise Dither for Pixel Depth Reduction

This block narrows a 10-bit-per-component RGB pixel stream to 6 or 8 bits per component. Before the low bits are dropped, a small pseudo-random value is added to each component, so that smooth gradients break up into fine noise instead of visible bands. The random values come from three 28-bit trinomial shift-register generators, one per colour channel. All three channels can instead draw from the red generator alone.

Pixels arrive with a valid strobe and markers for the start of a frame and the start of a line. Each result appears exactly one clock later, with the markers delayed to match. The configuration inputs are static while a stream runs. They select the output depth, the per-channel seeds, shared or separate generators, whether the generators reload at every frame, and an optional high-pass shaping of the noise.

Top module: `pix_noise_reduce`

## Requirements
- R1: While reset is asserted, outValid, outSof, outSol and all three output components are 0.
- R2: outValid, outSof and outSol equal inValid, inSof and inSol of the previous clock cycle.
- R3: When cfgEnable is 0, or cfgDepth is 2 or 3, each output component equals bits [9:2] of its input from the previous cycle, with no noise added.
- R4: With cfgDepth 0, a 4-bit noise value is added and the output is {sum[9:4], 2'b00}. With cfgDepth 1, a 2-bit noise value is added and the output is sum[9:2].
- R5: The sum of a component and its noise saturates at 1023 and never wraps.
- R6: Each generator is a 28-bit register that shifts toward the MSB, with new bit 0 = s[27] ^ s[k-1]. The noise for a pixel is the low 4 or 2 bits of the state in use for that pixel. The state steps once per valid pixel and holds in all other cycles.
- R7: When cfgSeparate is 0, all channels take noise from the red generator (k=3). When it is 1, red uses k=3, green k=9 and blue k=13, each with its own noise.
- R8: On the first clock edge after reset is released, each generator takes its seed. A seed that evaluates to zero is replaced by 1. A pixel valid in that cycle already uses the loaded seed.
- R9: A frame counter starts at 0 after reset and advances by one, modulo 16, on each valid start-of-frame pixel. When cfgFrameRandom is 1, each valid start-of-frame pixel uses, and steps from, seed XOR count in bits [3:0]. The XOR applies only when cfgDepth is 0 or 1, and the count is the value before it advances. When cfgFrameRandom is 0, a start of frame does not reload the generators.
- R10: With cfgHighPass set, the noise added is the current raw noise minus the same channel's raw noise from its previous valid pixel, both masked to the dropped bits, with a negative result clipped to 0. The previous value is 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cfgEnable | input | 1 | Enables noise and truncation to the selected depth |
| cfgDepth | input | 2 | 0: 6-bit result, 1: 8-bit result, 2/3: bypass |
| cfgSeparate | input | 1 | 1: one generator per channel, 0: red generator shared |
| cfgFrameRandom | input | 1 | Reload generators at each start of frame |
| cfgHighPass | input | 1 | Use the difference of consecutive noise samples |
| cfgSeedR | input | 28 | Red generator seed |
| cfgSeedG | input | 28 | Green generator seed |
| cfgSeedB | input | 28 | Blue generator seed |
| inValid | input | 1 | Input pixel valid |
| inSof | input | 1 | First pixel of a frame |
| inSol | input | 1 | First pixel of a line |
| inR | input | 10 | Red component |
| inG | input | 10 | Green component |
| inB | input | 10 | Blue component |
| outValid | output | 1 | Output pixel valid |
| outSof | output | 1 | Delayed start of frame |
| outSol | output | 1 | Delayed start of line |
| outR | output | 8 | Red result |
| outG | output | 8 | Green result |
| outB | output | 8 | Blue result |

## Verification
A generator that has stepped wrongly, or loaded the wrong value, changes the noise bits of the very next valid pixel. The error then persists for the rest of the frame, or for the whole run when frame reload is off. A frame counter that is off by one shows only at the next reloaded frame start, and then on every pixel of that frame. A wrong stored high-pass sample corrupts exactly the following pixel of that channel. For these reasons the bench compares every valid pixel against an independent model, one cycle after it is driven, across several frames and through the counter wrap.

// File: rtl/pnr_pkg.sv
package pnr_pkg;
  localparam int FRAME_CNT_W = 4;
  localparam int NOISE_W     = 4;
  localparam int DROP_DEEP   = 4;
  localparam int DROP_SHALLOW = 2;

  typedef struct packed {
    logic                   loadNow;
    logic                   advance;
    logic [FRAME_CNT_W-1:0] mixVal;
    logic                   active;
    logic                   dropFour;
    logic                   hpOn;
    logic                   separate;
  } pnr_ctl_t;

  function automatic int chanTap(input int idx);
    case (idx)
      0:       return 3;
      1:       return 9;
      default: return 13;
    endcase
  endfunction
endpackage

// File: rtl/pnr_lfsr.sv
module pnr_lfsr #(
  parameter int LW  = 28,
  parameter int TAP = 3,
  parameter int MW  = 4,
  parameter int NW  = 4
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [LW-1:0] seed,
  input  logic [MW-1:0] mix,
  input  logic          load,
  input  logic          advance,
  output logic [NW-1:0] noiseBits
);
  logic [LW-1:0] stateQ;
  logic [LW-1:0] seedMix;
  logic [LW-1:0] seedFix;
  logic [LW-1:0] srcState;

  always_comb begin
    seedMix   = seed ^ {{(LW-MW){1'b0}}, mix};
    seedFix   = (seedMix == '0) ? LW'(1) : seedMix;
    srcState  = load ? seedFix : stateQ;
    noiseBits = srcState[NW-1:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stateQ <= LW'(1);
    else if (advance) stateQ <= {srcState[LW-2:0], srcState[LW-1] ^ srcState[TAP-1]};
    else stateQ <= srcState;
  end

  // R8: the lock-up state is never entered
  a_r8_never_zero: assert property (@(posedge clk) disable iff (!rstN) stateQ != '0);
  // R6: no step and no load leaves the state untouched
  a_r6_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!advance && !load) |=> $stable(stateQ));
endmodule

// File: rtl/pnr_ctrl.sv
module pnr_ctrl
  import pnr_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  input  logic       inSof,
  input  logic       cfgEnable,
  input  logic [1:0] cfgDepth,
  input  logic       cfgSeparate,
  input  logic       cfgFrameRandom,
  input  logic       cfgHighPass,
  output pnr_ctl_t   ctl
);
  logic                   loadPending;
  logic [FRAME_CNT_W-1:0] frameCnt;
  logic                   frameStart;
  logic                   depthOk;

  always_comb begin
    frameStart   = inValid && inSof;
    depthOk      = !cfgDepth[1];
    ctl.loadNow  = loadPending || (frameStart && cfgFrameRandom);
    ctl.advance  = inValid;
    ctl.mixVal   = (cfgFrameRandom && depthOk) ? frameCnt : '0;
    ctl.active   = cfgEnable && depthOk;
    ctl.dropFour = (cfgDepth == 2'd0);
    ctl.hpOn     = cfgHighPass;
    ctl.separate = cfgSeparate;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      loadPending <= 1'b1;
      frameCnt    <= '0;
    end else begin
      loadPending <= 1'b0;
      if (frameStart) frameCnt <= frameCnt + 1'b1;
    end
  end

  // R9: the counter wraps from its top value to zero
  a_r9_cnt_wrap: assert property (@(posedge clk) disable iff (!rstN)
    (frameStart && (&frameCnt)) |=> (frameCnt == '0));
  // R8: the startup load happens once only
  a_r8_load_once: assert property (@(posedge clk) disable iff (!rstN)
    !loadPending |=> !loadPending);
endmodule

// File: rtl/pnr_datapath.sv
module pnr_datapath
  import pnr_pkg::*;
#(
  parameter int PIX_W = 10,
  parameter int LW    = 28,
  localparam int OUT_W = PIX_W - DROP_SHALLOW,
  localparam int NCH   = 3
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  pnr_ctl_t                  ctl,
  input  logic                      inValid,
  input  logic                      inSof,
  input  logic                      inSol,
  input  logic [NCH-1:0][PIX_W-1:0] inPix,
  input  logic [NCH-1:0][LW-1:0]    seeds,
  output logic                      outValid,
  output logic                      outSof,
  output logic                      outSol,
  output logic [NCH-1:0][OUT_W-1:0] outPix
);
  logic [NOISE_W-1:0] genNoise [NCH];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid <= 1'b0;
      outSof   <= 1'b0;
      outSol   <= 1'b0;
    end else begin
      outValid <= inValid;
      outSof   <= inSof;
      outSol   <= inSol;
    end
  end

  for (genvar i = 0; i < NCH; i++) begin : g_chan
    logic [NOISE_W-1:0] rawN, mask, curN, prvN, addN, prevQ;
    logic [PIX_W:0]     sum;
    logic [PIX_W-1:0]   sat;
    logic [OUT_W-1:0]   res;

    pnr_lfsr #(.LW(LW), .TAP(chanTap(i)), .MW(FRAME_CNT_W), .NW(NOISE_W)) u_gen (
      .clk(clk), .rstN(rstN), .seed(seeds[i]), .mix(ctl.mixVal),
      .load(ctl.loadNow), .advance(ctl.advance), .noiseBits(genNoise[i])
    );

    always_comb begin
      rawN = ctl.separate ? genNoise[i] : genNoise[0];
      mask = ctl.dropFour ? NOISE_W'((1 << DROP_DEEP) - 1) : NOISE_W'((1 << DROP_SHALLOW) - 1);
      curN = rawN & mask;
      prvN = prevQ & mask;
      if (ctl.hpOn) addN = (curN > prvN) ? (curN - prvN) : '0;
      else          addN = curN;
      sum = {1'b0, inPix[i]} + {{(PIX_W+1-NOISE_W){1'b0}}, addN};
      sat = sum[PIX_W] ? '1 : sum[PIX_W-1:0];
      if (!ctl.active)       res = inPix[i][PIX_W-1:DROP_SHALLOW];
      else if (ctl.dropFour) res = {sat[PIX_W-1:DROP_DEEP], {(DROP_DEEP-DROP_SHALLOW){1'b0}}};
      else                   res = sat[PIX_W-1:DROP_SHALLOW];
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        prevQ     <= '0;
        outPix[i] <= '0;
      end else begin
        if (inValid) prevQ <= rawN;
        outPix[i] <= res;
      end
    end

    // R5: with noise on, a result never falls below the plain truncation
    a_r5_no_wrap: assert property (@(posedge clk) disable iff (!rstN)
      (inValid && ctl.active && !ctl.dropFour) |=> (outPix[i] >= $past(inPix[i][PIX_W-1:DROP_SHALLOW])));
    // R4: the 6-bit result leaves its two low bits clear
    a_r4_low_zero: assert property (@(posedge clk) disable iff (!rstN)
      (inValid && ctl.active && ctl.dropFour) |=> (outPix[i][DROP_DEEP-DROP_SHALLOW-1:0] == '0));
    // R3: bypass passes the upper bits through
    a_r3_bypass: assert property (@(posedge clk) disable iff (!rstN)
      (inValid && !ctl.active) |=> (outPix[i] == $past(inPix[i][PIX_W-1:DROP_SHALLOW])));
  end
endmodule

// File: rtl/pix_noise_reduce.sv
module pix_noise_reduce
  import pnr_pkg::*;
#(
  parameter int PIX_W = 10,
  parameter int LW    = 28,
  localparam int OUT_W = PIX_W - DROP_SHALLOW
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgEnable,
  input  logic [1:0]       cfgDepth,
  input  logic             cfgSeparate,
  input  logic             cfgFrameRandom,
  input  logic             cfgHighPass,
  input  logic [LW-1:0]    cfgSeedR,
  input  logic [LW-1:0]    cfgSeedG,
  input  logic [LW-1:0]    cfgSeedB,
  input  logic             inValid,
  input  logic             inSof,
  input  logic             inSol,
  input  logic [PIX_W-1:0] inR,
  input  logic [PIX_W-1:0] inG,
  input  logic [PIX_W-1:0] inB,
  output logic             outValid,
  output logic             outSof,
  output logic             outSol,
  output logic [OUT_W-1:0] outR,
  output logic [OUT_W-1:0] outG,
  output logic [OUT_W-1:0] outB
);
  pnr_ctl_t                ctl;
  logic [2:0][OUT_W-1:0]   outPix;

  pnr_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inSof(inSof),
    .cfgEnable(cfgEnable), .cfgDepth(cfgDepth), .cfgSeparate(cfgSeparate),
    .cfgFrameRandom(cfgFrameRandom), .cfgHighPass(cfgHighPass), .ctl(ctl)
  );

  pnr_datapath #(.PIX_W(PIX_W), .LW(LW)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .inValid(inValid), .inSof(inSof), .inSol(inSol),
    .inPix({inB, inG, inR}), .seeds({cfgSeedB, cfgSeedG, cfgSeedR}),
    .outValid(outValid), .outSof(outSof), .outSol(outSol), .outPix(outPix)
  );

  assign outR = outPix[0];
  assign outG = outPix[1];
  assign outB = outPix[2];

  // R2: markers keep their one-cycle alignment with valid
  a_r2_sof_valid: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inSof) |=> (outValid && outSof));
endmodule

// File: tb/pix_noise_reduce_tb.sv
`timescale 1ns/1ps
module pix_noise_reduce_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cfgEnable = 1'b0, cfgSeparate = 1'b0, cfgFrameRandom = 1'b0, cfgHighPass = 1'b0;
  logic [1:0] cfgDepth = 2'd1;
  logic [27:0] cfgSeedR = 28'h0, cfgSeedG = 28'h0, cfgSeedB = 28'h0;
  logic inValid = 1'b0, inSof = 1'b0, inSol = 1'b0;
  logic [9:0] inR = '0, inG = '0, inB = '0;
  logic outValid, outSof, outSol;
  logic [7:0] outR, outG, outB;

  int nChecks = 0, nFails = 0;
  bit done = 1'b0;

  logic [27:0] mSt [3];
  logic [3:0]  mPrev [3];
  logic        mPend;
  logic [3:0]  mCnt;

  always #2.5 clk = ~clk;

  pix_noise_reduce dut_i (
    .clk(clk), .rstN(rstN), .cfgEnable(cfgEnable), .cfgDepth(cfgDepth),
    .cfgSeparate(cfgSeparate), .cfgFrameRandom(cfgFrameRandom), .cfgHighPass(cfgHighPass),
    .cfgSeedR(cfgSeedR), .cfgSeedG(cfgSeedG), .cfgSeedB(cfgSeedB),
    .inValid(inValid), .inSof(inSof), .inSol(inSol), .inR(inR), .inG(inG), .inB(inB),
    .outValid(outValid), .outSof(outSof), .outSol(outSol), .outR(outR), .outG(outG), .outB(outB)
  );

  task automatic chk(string req, string what, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic [27:0] stepM(logic [27:0] s, int k);
    return {s[26:0], s[27] ^ s[k-1]};
  endfunction

  function automatic int tapOf(int c);
    return (c == 0) ? 3 : (c == 1) ? 9 : 13;
  endfunction

  // Bench is at a falling edge on entry and on exit.
  task automatic doReset();
    rstN = 1'b0; inValid = 0; inSof = 0; inSol = 0;
    for (int c = 0; c < 3; c++) begin mSt[c] = 28'd1; mPrev[c] = '0; end
    mPend = 1'b1; mCnt = '0;
    repeat (2) @(posedge clk);
    #1;
    chk("R1", "outValid", outValid, 0);
    chk("R1", "outSof", outSof, 0);
    chk("R1", "outSol", outSol, 0);
    chk("R1", "outR", outR, 0);
    chk("R1", "outG", outG, 0);
    chk("R1", "outB", outB, 0);
    @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic tick(bit v, bit sof, bit sol, int r, int g, int b, string req);
    logic [27:0] seedArr [3];
    logic [27:0] src [3];
    logic [27:0] eff;
    int pix [3];
    int expo [3];
    int dropBits, mask, raw, cur, prv, n, sum;
    bit act, loadNow;
    logic [3:0] mix;
    pix[0] = r; pix[1] = g; pix[2] = b;
    seedArr[0] = cfgSeedR; seedArr[1] = cfgSeedG; seedArr[2] = cfgSeedB;
    inValid = v; inSof = sof; inSol = sol;
    inR = 10'(r); inG = 10'(g); inB = 10'(b);
    act = cfgEnable && (cfgDepth < 2);
    dropBits = (cfgDepth == 0) ? 4 : 2;
    mask = (1 << dropBits) - 1;
    loadNow = mPend || (v && sof && cfgFrameRandom);
    mix = (cfgFrameRandom && cfgDepth < 2) ? mCnt : 4'd0;
    for (int c = 0; c < 3; c++) begin
      eff = seedArr[c] ^ {24'd0, mix};
      if (eff == 0) eff = 28'd1;
      src[c] = loadNow ? eff : mSt[c];
    end
    for (int c = 0; c < 3; c++) begin
      raw = cfgSeparate ? int'(src[c][3:0]) : int'(src[0][3:0]);
      cur = raw & mask;
      prv = int'(mPrev[c]) & mask;
      n = cfgHighPass ? ((cur > prv) ? cur - prv : 0) : cur;
      sum = pix[c] + n;
      if (sum > 1023) sum = 1023;
      if (!act) expo[c] = pix[c] >> 2;
      else if (dropBits == 4) expo[c] = (sum >> 4) << 2;
      else expo[c] = sum >> 2;
      if (v) mPrev[c] = 4'(raw);
    end
    for (int c = 0; c < 3; c++) mSt[c] = v ? stepM(src[c], tapOf(c)) : src[c];
    mPend = 1'b0;
    if (v && sof) mCnt = mCnt + 4'd1;
    @(posedge clk);
    #1;
    chk("R2", "outValid", outValid, int'(v));
    chk("R2", "outSof", outSof, int'(sof));
    chk("R2", "outSol", outSol, int'(sol));
    if (v) begin
      chk(req, "outR", outR, expo[0]);
      chk(req, "outG", outG, expo[1]);
      chk(req, "outB", outB, expo[2]);
    end
    @(negedge clk);
    inValid = 0; inSof = 0; inSol = 0;
  endtask

  function automatic int pat(int i, int c);
    return (i * 97 + c * 311 + 13) % 1024;
  endfunction

  task automatic runFrame(int lines, int perLine, int base, bit gaps, string req);
    int idx = base;
    for (int l = 0; l < lines; l++)
      for (int p = 0; p < perLine; p++) begin
        tick(1'b1, (l == 0) && (p == 0), p == 0, pat(idx, 0), pat(idx, 1), pat(idx, 2), req);
        if (gaps && (p % 3 == 1)) tick(1'b0, 1'b0, 1'b0, 0, 0, 0, req);
        idx++;
      end
  endtask

  task automatic setSeeds(logic [27:0] r, logic [27:0] g, logic [27:0] b);
    cfgSeedR = r; cfgSeedG = g; cfgSeedB = b;
  endtask

  task automatic t_bypass();
    cfgEnable = 0; cfgDepth = 2'd1;
    runFrame(2, 6, 0, 1'b0, "R3");
    cfgEnable = 1; cfgDepth = 2'd2;
    runFrame(2, 6, 40, 1'b0, "R3");
    cfgDepth = 2'd3;
    runFrame(1, 6, 90, 1'b0, "R3");
  endtask

  task automatic t_shared_d1();
    cfgEnable = 1; cfgDepth = 2'd1; cfgSeparate = 0;
    runFrame(3, 10, 200, 1'b0, "R4 R6 R7");
  endtask

  task automatic t_separate_d0();
    cfgEnable = 1; cfgDepth = 2'd0; cfgSeparate = 1;
    runFrame(3, 10, 400, 1'b0, "R4 R7");
  endtask

  task automatic t_gaps();
    cfgEnable = 1; cfgDepth = 2'd0; cfgSeparate = 1;
    runFrame(2, 9, 600, 1'b1, "R6");
  endtask

  task automatic t_saturate();
    cfgEnable = 1; cfgSeparate = 1; cfgHighPass = 0;
    for (int d = 0; d < 2; d++) begin
      cfgDepth = 2'(d);
      for (int i = 0; i < 12; i++) tick(1'b1, i == 0, i == 0, 1023 - (i % 4), 1022, 1020 + (i % 3), "R5");
    end
  endtask

  task automatic t_zero_seed();
    setSeeds(28'h0, 28'h0, 28'h0);
    doReset();
    cfgEnable = 1; cfgDepth = 2'd0; cfgSeparate = 1;
    runFrame(2, 8, 700, 1'b0, "R8");
  endtask

  task automatic t_frame_random();
    setSeeds(28'h5A5A5A5, 28'h0C0FFEE, 28'h1234567);
    doReset();
    cfgEnable = 1; cfgSeparate = 1; cfgFrameRandom = 1;
    for (int f = 0; f < 18; f++) begin
      cfgDepth = (f % 2 == 0) ? 2'd0 : 2'd1;
      runFrame(1, 4, 800 + f * 4, 1'b0, "R9");
    end
    cfgDepth = 2'd2; cfgEnable = 1;
    runFrame(1, 3, 20, 1'b0, "R9");
    cfgDepth = 2'd1;
    runFrame(1, 4, 30, 1'b0, "R9");
    cfgFrameRandom = 0;
    for (int f = 0; f < 3; f++) runFrame(1, 4, 60 + f, 1'b0, "R9");
  endtask

  task automatic t_highpass();
    cfgEnable = 1; cfgSeparate = 1; cfgHighPass = 1; cfgFrameRandom = 0;
    cfgDepth = 2'd0;
    runFrame(2, 10, 900, 1'b1, "R10");
    cfgDepth = 2'd1; cfgSeparate = 0;
    runFrame(2, 10, 950, 1'b0, "R10");
    cfgHighPass = 0;
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 150000);
    nChecks++; nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    setSeeds(28'hACE1234, 28'h0BADC0D, 28'h7654321);
    @(negedge clk);
    doReset();
    t_bypass();
    t_shared_d1();
    t_separate_d0();
    t_gaps();
    t_saturate();
    t_highpass();
    t_zero_seed();
    t_frame_random();
    finishRun();
  end
endmodule